// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical address by reading up to four levels of 64-bit translation entries from memory. A lookup is offered on a valid/ready request channel. The walker first checks that the upper address bits are a proper sign extension. It then fetches one entry per level through a single-outstanding memory port. Each entry is checked for presence and for reserved bits. User, write and no-execute rights are folded across the levels. The accessed flag is set on intermediate entries, and the accessed and dirty flags are set on the final entry. Every entry that changes is written back to memory.

A walk stops early when an entry at the 1 GB or 2 MB level has its large-page flag set. The result comes back on a valid/ready response channel. It carries the physical address, a page size code, the folded rights and a fault class. The response is held unchanged while `rsp_ready` is low, and no new lookup is accepted until the response has been taken. The memory request is likewise held stable while `mem_req_ready` is low. A read's data arrives later as a one-cycle `mem_rsp_valid` pulse. A write completes when it is accepted. The table root, the no-execute enable and the address-line mask are plain control inputs and must stay stable during a walk.

Top module: `pgwalk_top`

## Requirements
- R1: If bits 63:47 of the virtual address are not all equal, the lookup ends with fault class 3 (general protection) and no memory access is made. A sign-extended address is walked normally.
- R2: Levels are visited from the top down, using address bits 47:39, then 38:30, then 29:21, then 20:12. Each entry address is (table base with bits 11:0 cleared) + index*8, ANDed with `a20_mask`. The first table base is `root_base`, and each later base is the frame field (bits 51:12) of the entry above.
- R3: An entry with bit 0 (present) clear ends the walk with fault class 1.
- R4: An entry ends the walk with fault class 2 if any of these holds: a bit in 62:52 is set; bit 63 (no-execute) is set while `nx_en` is 0; or bit 7 (large page) is set in a top-level entry.
- R5: Bit 7 set at the 38:30 level ends the walk with a 1 GB page (size code 2). Bit 7 set at the 29:21 level ends it with a 2 MB page (size code 1). Otherwise the page is 4 KB (size code 0). The physical address is the leaf frame aligned to the page size, ORed with the virtual address bits below the page size.
- R6: In a large-page leaf, a set frame bit below the page size, other than bit 12, gives fault class 2. Bit 12 is ignored for the address.
- R7: An intermediate entry whose bit 5 (accessed) is clear is written back with bit 5 set before the next level is read. An intermediate entry with bit 5 already set is not written.
- R8: `rsp_user` is the AND of bit 2 over all levels visited. The write right is the AND of bit 1 over all levels. `rsp_nx` is the OR of bit 63 over all levels.
- R9: On a successful leaf, bit 5 is set, and bit 6 (dirty) is set if `req_write` is 1. The leaf is written back only if this changed it. `rsp_wr` is 0 when the final leaf is not dirty.
- R10: One memory access is outstanding at a time. Any writeback completes before the response is raised. Request and response hold their values under back-pressure. `req_ready` is high only when the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle, lookup accepted |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| root_base | input | 52 | Top-level table base (bits 11:0 ignored) |
| nx_en | input | 1 | No-execute bit enabled |
| a20_mask | input | 52 | Mask ANDed into every entry address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 reserved bit, 3 general protection |
| rsp_paddr | output | 52 | Physical address |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_user | output | 1 | Folded user right |
| rsp_wr | output | 1 | Folded write right, withheld if leaf clean |
| rsp_nx | output | 1 | Folded no-execute |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory access accepted |
| mem_req_we | output | 1 | 1 = writeback, 0 = read |
| mem_req_addr | output | 52 | Entry address |
| mem_req_wdata | output | 64 | Writeback data |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_rdata | input | 64 | Read data |

## Verification
The leaf writeback and the release of the result can collide. A clean leaf reached under memory stall must have its accessed and dirty update accepted by memory before `rsp_valid` rises, and that result must then stay frozen while the consumer withholds `rsp_ready`. The bench provokes this by running the memory with a ready pattern that accepts only one cycle in three, and by holding `rsp_ready` low for several cycles after the result appears. It judges the outcome by the writeback count seen at the moment the result shows, and by comparing every held output cycle by cycle.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ENT_W = 64;

  localparam int B_P   = 0;
  localparam int B_RW  = 1;
  localparam int B_US  = 2;
  localparam int B_A   = 5;
  localparam int B_D   = 6;
  localparam int B_PS  = 7;
  localparam int B_NX  = 63;

  localparam logic [ENT_W-1:0] M_P  = ENT_W'(1) << B_P;
  localparam logic [ENT_W-1:0] M_RW = ENT_W'(1) << B_RW;
  localparam logic [ENT_W-1:0] M_US = ENT_W'(1) << B_US;
  localparam logic [ENT_W-1:0] M_A  = ENT_W'(1) << B_A;
  localparam logic [ENT_W-1:0] M_D  = ENT_W'(1) << B_D;
  localparam logic [ENT_W-1:0] M_PS = ENT_W'(1) << B_PS;
  localparam logic [ENT_W-1:0] M_NX = ENT_W'(1) << B_NX;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RSVD   = 2'd2,
    FLT_GP     = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WB,
    ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic user;
    logic wr;
    logic nx;
  } rights_t;
endpackage

// File: rtl/pgw_entry_chk.sv
module pgw_entry_chk
  import pgw_pkg::*;
#(
  parameter int PA_W      = 52,
  parameter int LEVELS    = 4,
  parameter int IDX_W     = 9,
  parameter int PG_SHIFT  = 12,
  parameter int LARGE_MAX = 2,
  parameter int LVL_W     = $clog2(LEVELS)
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] lvl,
  input  logic             nx_en,
  output logic             present,
  output logic             rsvd,
  output logic             big,
  output logic             leaf
);
  // bits above the physical width, below the no-execute bit
  localparam logic [ENT_W-1:0] HI_MASK =
    {1'b0, {(ENT_W-1-PA_W){1'b1}}, {PA_W{1'b0}}};

  logic ps_set, hi_rsvd, nx_rsvd, ps_rsvd, lo_rsvd;

  assign present = (entry & M_P) != '0;
  assign ps_set  = (entry & M_PS) != '0;
  assign hi_rsvd = (entry & HI_MASK) != '0;
  assign nx_rsvd = !nx_en && ((entry & M_NX) != '0);
  assign ps_rsvd = ps_set && (int'(lvl) > LARGE_MAX);
  assign big     = ps_set && (lvl != '0) && (int'(lvl) <= LARGE_MAX);
  assign leaf    = big || (lvl == '0);

  // frame bits under a large page must be clear; the lowest one is skipped
  always_comb begin
    lo_rsvd = 1'b0;
    for (int i = PG_SHIFT + 1; i < PA_W; i++) begin
      if ((i < PG_SHIFT + IDX_W * int'(lvl)) && entry[i]) lo_rsvd = 1'b1;
    end
    lo_rsvd = lo_rsvd && big;
  end

  assign rsvd = hi_rsvd || nx_rsvd || ps_rsvd || lo_rsvd;
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int PA_W     = 52,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  parameter int LVL_W    = $clog2(LEVELS),
  parameter int VA_W     = PG_SHIFT + IDX_W * LEVELS
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [PA_W-1:0]  a20_mask,
  input  logic [PA_W-1:0]  leaf_ent,
  output logic [PA_W-1:0]  ent_addr,
  output logic [PA_W-1:0]  phys
);
  localparam logic [PA_W-1:0] PG_LOW = PA_W'((64'd1 << PG_SHIFT) - 64'd1);

  logic [IDX_W-1:0] idx_v [LEVELS];
  logic [PA_W-1:0]  pa_v  [LEVELS];
  logic [PA_W-1:0]  va_ext;

  assign va_ext = {{(PA_W-VA_W){1'b0}}, va};

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int SH = PG_SHIFT + IDX_W * g;
    localparam logic [PA_W-1:0] LOW = PA_W'((64'd1 << SH) - 64'd1);
    assign idx_v[g] = va[SH +: IDX_W];
    assign pa_v[g]  = (leaf_ent & ~LOW) | (va_ext & LOW);
  end

  assign ent_addr = ((tbl_base & ~PG_LOW) +
                     {{(PA_W-IDX_W-3){1'b0}}, idx_v[lvl], 3'b000}) & a20_mask;
  assign phys = pa_v[lvl];
endmodule

// File: rtl/pgw_rights.sv
module pgw_rights
  import pgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fold,
  input  logic [ENT_W-1:0] entry,
  output rights_t          acc
);
  logic u_q, w_q, x_q;  // x_q: execution still allowed

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q <= 1'b1;
      w_q <= 1'b1;
      x_q <= 1'b1;
    end else if (clear) begin
      u_q <= 1'b1;
      w_q <= 1'b1;
      x_q <= 1'b1;
    end else if (fold) begin
      u_q <= u_q && ((entry & M_US) != '0);
      w_q <= w_q && ((entry & M_RW) != '0);
      x_q <= x_q && ((entry & M_NX) == '0);
    end
  end

  assign acc = '{user: u_q, wr: w_q, nx: !x_q};

  AST_USER_STAYS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && !u_q) |=> !u_q);  // R8
  AST_NX_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && ((entry & M_NX) != '0)) |=> !x_q);  // R8
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int PA_W      = 52,
  parameter int LEVELS    = 4,
  parameter int IDX_W     = 9,
  parameter int PG_SHIFT  = 12,
  parameter int LARGE_MAX = 2,
  parameter int LVL_W     = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_vaddr,
  input  logic             req_write,
  input  logic [PA_W-1:0]  root_base,
  input  logic             nx_en,
  input  logic [PA_W-1:0]  a20_mask,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [LVL_W-1:0] rsp_size,
  output logic             rsp_user,
  output logic             rsp_wr,
  output logic             rsp_nx,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_rdata
);
  localparam int VA_W = PG_SHIFT + IDX_W * LEVELS;

  walk_st_e         st;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [63:0]      ent_q;
  logic             leaf_q;
  fault_e           fault_q;
  logic [PA_W-1:0]  paddr_q;
  logic [LVL_W-1:0] size_q;
  logic             dirty_q;

  logic             canon;
  logic             e_present, e_rsvd, e_big, e_leaf;
  logic [PA_W-1:0]  ent_addr, phys;
  logic [63:0]      leaf_upd;
  logic             r_clear, r_fold, ok;
  rights_t          acc;

  assign canon = (&req_vaddr[63:VA_W-1]) || !(|req_vaddr[63:VA_W-1]);

  pgw_entry_chk #(
    .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT),
    .LARGE_MAX(LARGE_MAX), .LVL_W(LVL_W)
  ) u_chk (
    .entry(mem_rsp_rdata), .lvl(lvl_q), .nx_en(nx_en),
    .present(e_present), .rsvd(e_rsvd), .big(e_big), .leaf(e_leaf)
  );

  pgw_addr_gen #(
    .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT),
    .LVL_W(LVL_W), .VA_W(VA_W)
  ) u_addr (
    .va(va_q), .lvl(lvl_q), .tbl_base(base_q), .a20_mask(a20_mask),
    .leaf_ent(mem_rsp_rdata[PA_W-1:0]), .ent_addr(ent_addr), .phys(phys)
  );

  assign r_clear = (st == ST_IDLE) && req_valid;
  assign r_fold  = (st == ST_RD_WAIT) && mem_rsp_valid && e_present && !e_rsvd;

  pgw_rights u_rights (
    .clk(clk), .rst_n(rst_n), .clear(r_clear), .fold(r_fold),
    .entry(mem_rsp_rdata), .acc(acc)
  );

  assign leaf_upd = mem_rsp_rdata | M_A | (wr_q ? M_D : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      ent_q   <= '0;
      leaf_q  <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
      size_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_vaddr[VA_W-1:0];
          wr_q    <= req_write;
          lvl_q   <= LVL_W'(LEVELS - 1);
          base_q  <= root_base;
          paddr_q <= '0;
          size_q  <= '0;
          dirty_q <= 1'b0;
          if (canon) begin
            fault_q <= FLT_NONE;
            st      <= ST_RD_REQ;
          end else begin
            fault_q <= FLT_GP;
            st      <= ST_DONE;
          end
        end
        ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (!e_present) begin
            fault_q <= FLT_ABSENT;
            st      <= ST_DONE;
          end else if (e_rsvd) begin
            fault_q <= FLT_RSVD;
            st      <= ST_DONE;
          end else if (e_leaf) begin
            ent_q   <= leaf_upd;
            leaf_q  <= 1'b1;
            paddr_q <= phys;
            size_q  <= lvl_q;
            dirty_q <= (leaf_upd & M_D) != '0;
            st      <= (leaf_upd != mem_rsp_rdata) ? ST_WB : ST_DONE;
          end else begin
            ent_q  <= mem_rsp_rdata | M_A;
            leaf_q <= 1'b0;
            if ((mem_rsp_rdata & M_A) == '0) begin
              st <= ST_WB;
            end else begin
              base_q <= mem_rsp_rdata[PA_W-1:0];
              lvl_q  <= lvl_q - LVL_W'(1);
              st     <= ST_RD_REQ;
            end
          end
        end
        ST_WB: if (mem_req_ready) begin
          if (leaf_q) begin
            st <= ST_DONE;
          end else begin
            base_q <= ent_q[PA_W-1:0];
            lvl_q  <= lvl_q - LVL_W'(1);
            st     <= ST_RD_REQ;
          end
        end
        ST_DONE: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_WB);
  assign mem_req_we    = (st == ST_WB);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = mem_req_we ? ent_q : '0;

  assign ok        = (fault_q == FLT_NONE);
  assign rsp_valid = (st == ST_DONE);
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;
  assign rsp_size  = size_q;
  assign rsp_user  = ok && acc.user;
  assign rsp_wr    = ok && acc.wr && dirty_q;
  assign rsp_nx    = ok && acc.nx;

  AST_GP_SKIPS_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !canon) |=> (rsp_valid && rsp_fault == FLT_GP));  // R1
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));  // R2
  AST_WB_MARKS_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_wdata[B_A] && mem_req_wdata[B_P]));  // R7
  AST_CLEAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr) |-> (rsp_fault == FLT_NONE));  // R9
  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));  // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_wr)));  // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);  // R10
endmodule

// File: tb/tb_pgwalk_top.sv
module tb_pgwalk_top;
  localparam logic [63:0] F_P  = 64'h1;
  localparam logic [63:0] F_W  = 64'h2;
  localparam logic [63:0] F_U  = 64'h4;
  localparam logic [63:0] F_A  = 64'h20;
  localparam logic [63:0] F_D  = 64'h40;
  localparam logic [63:0] F_PS = 64'h80;
  localparam logic [63:0] F_NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_IM = F_P | F_W | F_U | F_A;

  localparam logic [51:0] T4 = 52'h1000, T3 = 52'h2000, T2 = 52'h3000, T1 = 52'h4000;
  localparam logic [51:0] A4 = T4 + 52'd8, A3 = T3 + 52'd16, A2 = T2 + 52'd24, A1 = T1 + 52'd32;
  localparam logic [63:0] VA0 = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd4 << 12) | 64'h567;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, nx_en = 1'b1, rsp_ready = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [51:0] root_base = T4, a20_mask = '1;
  logic        req_ready, rsp_valid, rsp_user, rsp_wr, rsp_nx;
  logic [1:0]  rsp_fault, rsp_size;
  logic [51:0] rsp_paddr, mem_req_addr;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] mem_req_wdata, mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  pgwalk_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .root_base(root_base),
    .nx_en(nx_en), .a20_mask(a20_mask), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_size(rsp_size),
    .rsp_user(rsp_user), .rsp_wr(rsp_wr), .rsp_nx(rsp_nx),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_checks = 0, n_err = 0, cyc = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  // memory model, evaluated between clock edges
  logic [63:0] mem [logic [51:0]];
  int          rd_cnt = 0, wr_cnt = 0, phase = 0;
  logic [51:0] rd_log [8];
  logic [51:0] wr_log [4];
  bit          stall = 1'b0, pend = 1'b0;
  logic [51:0] pend_a = '0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = mem.exists(pend_a) ? mem[pend_a] : 64'h0;
      pend = 1'b0;
    end
    phase = (phase + 1) % 3;
    mem_req_ready = !stall || (phase == 0);
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        if (wr_cnt < 4) wr_log[wr_cnt] = mem_req_addr;
        wr_cnt++;
      end else begin
        pend = 1'b1;
        pend_a = mem_req_addr;
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  logic [1:0]  g_fault, g_size;
  logic [51:0] g_paddr;
  logic        g_user, g_wr, g_nx;
  int          g_wr_at_rsp;

  task automatic build(input logic [63:0] e4, input logic [63:0] e3, input logic [63:0] e2, input logic [63:0] e1);
    mem.delete();
    mem[A4] = e4;
    mem[A3] = e3;
    mem[A2] = e2;
    mem[A1] = e1;
  endtask

  task automatic run_walk(input logic [63:0] va, input logic wr, input int hold);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    g_wr_at_rsp = wr_cnt;
    g_fault = rsp_fault; g_size = rsp_size; g_paddr = rsp_paddr;
    g_user = rsp_user; g_wr = rsp_wr; g_nx = rsp_nx;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R10", "result held under back-pressure",
            {rsp_valid, rsp_fault, rsp_paddr, rsp_wr}, {1'b1, g_fault, g_paddr, g_wr});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R10", "idle after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
  endtask

  task automatic t_basic_4k;
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM, 64'hABCDE000 | F_P | F_W | F_U);
    run_walk(VA0, 1'b0, 0);
    check("R5", "4K fault", g_fault, 0);
    check("R5", "4K paddr", g_paddr, 52'hABCDE567);
    check("R5", "4K size", g_size, 0);
    check("R2", "level order", {rd_log[0], rd_log[1], rd_log[2], rd_log[3]}, {A4, A3, A2, A1});
    check("R9", "clean leaf gets accessed only", mem[A1], 64'hABCDE000 | F_P | F_W | F_U | F_A);
    check("R9", "one leaf writeback", wr_cnt, 1);
    check("R9", "clean leaf withholds write", g_wr, 0);
    check("R8", "user right", g_user, 1);
  endtask

  task automatic t_write_dirty;
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM, 64'hABCDE000 | F_IM);
    run_walk(VA0, 1'b1, 0);
    check("R9", "write sets dirty", mem[A1], 64'hABCDE000 | F_IM | F_D);
    check("R9", "dirty leaf grants write", g_wr, 1);
    run_walk(VA0, 1'b1, 0);
    check("R9", "unchanged leaf not written", wr_cnt, 0);
    check("R9", "still writable", g_wr, 1);
  endtask

  task automatic t_inter_accessed;
    build(T3 | F_IM, T2 | F_P | F_W | F_U, T1 | F_IM, 64'hABCDE000 | F_IM | F_D);
    run_walk(VA0, 1'b0, 0);
    check("R7", "single intermediate writeback", wr_cnt, 1);
    check("R7", "writeback target", wr_log[0], A3);
    check("R7", "accessed set in memory", mem[A3], T2 | F_IM);
    check("R7", "walk continues to leaf", rd_cnt, 4);
    check("R7", "result", {g_fault, g_paddr}, {2'd0, 52'hABCDE567});
  endtask

  task automatic t_large;
    build(T3 | F_IM, T2 | F_IM, 64'h4000_0000 | F_IM | F_D | F_PS, 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R5", "2M paddr", g_paddr, 52'h4000_4567);
    check("R5", "2M size and reads", {g_size, 4'(rd_cnt), 4'(wr_cnt)}, {2'd1, 4'd3, 4'd0});
    build(T3 | F_IM, 64'h8000_0000 | F_IM | F_D | F_PS, 64'h0, 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R5", "1G paddr", g_paddr, 52'h8060_4567);
    check("R5", "1G size and reads", {g_size, 4'(rd_cnt)}, {2'd2, 4'd2});
  endtask

  task automatic t_large_rsvd;
    build(T3 | F_IM, T2 | F_IM, 64'h4000_2000 | F_IM | F_D | F_PS, 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R6", "low frame bit in 2M leaf", g_fault, 2);
    build(T3 | F_IM, T2 | F_IM, 64'h4000_1000 | F_IM | F_D | F_PS, 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R6", "bit 12 tolerated", {g_fault, g_paddr}, {2'd0, 52'h4000_4567});
  endtask

  task automatic t_absent;
    build(T3 | F_IM, T2 | F_IM, T1 | F_W | F_U | F_A, 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R3", "not present fault", g_fault, 1);
    check("R3", "stops at level", {4'(rd_cnt), 4'(wr_cnt)}, {4'd3, 4'd0});
  endtask

  task automatic t_canon;
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM, 64'hABCDE000 | F_IM | F_D);
    run_walk(VA0 | (64'd1 << 50), 1'b0, 0);
    check("R1", "non-canonical fault", g_fault, 3);
    check("R1", "no memory access", rd_cnt + wr_cnt, 0);
    run_walk(64'hFFFF_8000_0000_0000, 1'b0, 0);
    check("R1", "sign-extended walks", {g_fault, 4'(rd_cnt)}, {2'd1, 4'd1});
  endtask

  task automatic t_rsvd;
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM, 64'hABCDE000 | F_IM | F_D | F_NX);
    nx_en = 1'b0;
    run_walk(VA0, 1'b0, 0);
    check("R4", "nx reserved when disabled", g_fault, 2);
    nx_en = 1'b1;
    run_walk(VA0, 1'b0, 0);
    check("R8", "nx folded", {g_fault, g_nx}, {2'd0, 1'b1});
    build(T3 | F_IM | F_PS, T2 | F_IM, T1 | F_IM, 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R4", "large flag at top", {g_fault, 4'(rd_cnt)}, {2'd2, 4'd1});
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM | (64'd1 << 55), 64'h0);
    run_walk(VA0, 1'b0, 0);
    check("R4", "high reserved bit", g_fault, 2);
  endtask

  task automatic t_rights;
    build(T3 | F_IM | F_NX, T2 | F_P | F_U | F_A, T1 | F_P | F_W | F_A, 64'hABCDE000 | F_IM | F_D);
    run_walk(VA0, 1'b1, 0);
    check("R8", "folded user/write/nx", {g_fault, g_user, g_wr, g_nx}, {2'd0, 1'b0, 1'b0, 1'b1});
  endtask

  task automatic t_a20;
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM, 64'hABCDE000 | F_IM | F_D);
    root_base = 52'h10_1000;
    a20_mask = ~(52'd1 << 20);
    run_walk(VA0, 1'b0, 0);
    check("R2", "masked first address", rd_log[0], A4);
    check("R2", "masked walk result", {g_fault, g_paddr}, {2'd0, 52'hABCDE567});
    root_base = T4;
    a20_mask = '1;
  endtask

  task automatic t_backpressure;
    build(T3 | F_IM, T2 | F_IM, T1 | F_IM, 64'hABCDE000 | F_P | F_W | F_U);
    stall = 1'b1;
    run_walk(VA0, 1'b1, 3);
    stall = 1'b0;
    check("R10", "writeback before result", g_wr_at_rsp, 1);
    check("R10", "stalled result", {g_fault, g_paddr, g_wr}, {2'd0, 52'hABCDE567, 1'b1});
    check("R10", "idle after handshake", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_4k();
    t_write_dirty();
    t_inter_accessed();
    t_large();
    t_large_rsvd();
    t_absent();
    t_canon();
    t_rsvd();
    t_rights();
    t_a20();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule